// File: doc/BRIEF.md
# ECC error reporting and capture unit

This block records ECC events reported by two memory ports, one for flash and one for RAM. Each port can signal a corrected single-bit error or a non-correctable error. With each event it presents the failing address, the number of the bus master, the access attributes and the data word. The RAM port also presents the ECC syndrome. Software controls which classes of event are logged through an 8-bit configuration byte. Logged events set sticky status flags, and a single interrupt line stays high while any flag is set.

For each memory the block keeps one capture set, so software can inspect the most important recent failure on that memory. A non-correctable error is logged even when the bus master drops it, for example a discarded speculative fetch or a buffered write. Single-bit reporting also depends on a hardware strap input that software cannot change. A plain register bus gives access to the configuration byte, the status byte and the capture registers. Reads on this bus are combinational and writes take effect at the clock edge.

Top module: `ecc_log_unit`

## Requirements
- R1: The configuration byte at bus address 0x43 resets to 0x00 and reads back only its four writable bits: bit 5 enables RAM single-bit, bit 4 enables flash single-bit, bit 1 enables RAM non-correctable, bit 0 enables flash non-correctable. Bits 7, 6, 3 and 2 read 0, and read data bits 31:8 read 0.
- R2: A non-correctable event on a memory whose enable is set raises that memory's flag in the status byte at address 0x47 at the next clock edge. The status byte uses the same bit positions as the configuration byte. With the enable clear, the event sets no flag.
- R3: A single-bit event sets its flag only when both its configuration bit and the strap input are high.
- R4: Status flags are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear of its bit leaves the bit set.
- R5: The interrupt output is high exactly while any status flag is set. It rises one cycle after an enabled event.
- R6: On an enabled event the capture set of that memory loads address, master number, attributes and data. Flash reads at 0x50, 0x54, 0x58 and 0x5C; RAM reads at 0x60, 0x64, 0x68 and 0x6C, each value zero-extended to 32 bits.
- R7: The RAM capture set also loads the syndrome, readable at 0x70. The flash capture set has no syndrome.
- R8: A capture set changes only on an enabled event of its own memory. Disabled events leave it unchanged.
- R9: A non-correctable event overwrites a single-bit capture. A single-bit event does not overwrite the capture while that memory's non-correctable flag is set, and captures again once the flag is cleared.
- R10: Flash and RAM events in the same cycle each load their own capture set.
- R11: Capture registers are read-only, and bus writes to their addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sb_strap | input | 1 | Hardware permit for single-bit reporting |
| fl_sb_evt | input | 1 | Flash single-bit correction event |
| fl_nc_evt | input | 1 | Flash non-correctable event |
| fl_addr | input | ADDR_W | Flash failing address |
| fl_master | input | MSTR_W | Flash bus master number |
| fl_attr | input | ATTR_W | Flash access attributes |
| fl_data | input | DATA_W | Flash data word |
| ram_sb_evt | input | 1 | RAM single-bit correction event |
| ram_nc_evt | input | 1 | RAM non-correctable event |
| ram_addr | input | ADDR_W | RAM failing address |
| ram_master | input | MSTR_W | RAM bus master number |
| ram_attr | input | ATTR_W | RAM access attributes |
| ram_data | input | DATA_W | RAM data word |
| ram_syndrome | input | SYN_W | RAM ECC syndrome |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when high, read when low |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 32 | Read data, zero when not reading |
| irq | output | 1 | Error interrupt |

## Verification
A wrong enable gate or a lost strap qualification shows up as a wrong status byte and interrupt level on the cycle after the event. The bench checks that pattern across a table of configuration, strap and event combinations. If the capture priority is corrupted, the capture address reads back the later single-bit address instead of the held non-correctable one right after the second event. If the clear-write interaction is broken, a flag drops on the same-cycle set-and-clear test. Wrong cross-memory gating shows up as a capture set changing when the other memory reports.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int REG_AW = 8;
  localparam int RD_W   = 32;

  typedef logic [REG_AW-1:0] reg_addr_t;

  // Register offsets
  localparam reg_addr_t OFS_CFG      = 8'h43;
  localparam reg_addr_t OFS_STATUS   = 8'h47;
  localparam reg_addr_t OFS_FL_ADDR  = 8'h50;
  localparam reg_addr_t OFS_FL_MSTR  = 8'h54;
  localparam reg_addr_t OFS_FL_ATTR  = 8'h58;
  localparam reg_addr_t OFS_FL_DATA  = 8'h5C;
  localparam reg_addr_t OFS_RAM_ADDR = 8'h60;
  localparam reg_addr_t OFS_RAM_MSTR = 8'h64;
  localparam reg_addr_t OFS_RAM_ATTR = 8'h68;
  localparam reg_addr_t OFS_RAM_DATA = 8'h6C;
  localparam reg_addr_t OFS_RAM_SYN  = 8'h70;

  // Bit positions, shared by configuration and status bytes
  localparam int BIT_FL_NC  = 0;
  localparam int BIT_RAM_NC = 1;
  localparam int BIT_FL_SB  = 4;
  localparam int BIT_RAM_SB = 5;

  localparam logic [7:0] LOG_MASK = 8'h33;
endpackage

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sb_strap,
  input  logic       wr_en,
  input  reg_addr_t  wr_addr,
  input  logic [7:0] wr_data,
  input  logic       fl_sb_evt,
  input  logic       fl_nc_evt,
  input  logic       ram_sb_evt,
  input  logic       ram_nc_evt,
  output logic [7:0] cfg_q,
  output logic [7:0] status_q,
  output logic       fl_sb_acc,
  output logic       fl_nc_acc,
  output logic       ram_sb_acc,
  output logic       ram_nc_acc,
  output logic       fl_nc_pend,
  output logic       ram_nc_pend,
  output logic       irq
);

  logic       cfg_en;
  logic [7:0] cfg_d;
  logic       status_en;
  logic [7:0] status_d;
  logic [7:0] set_vec;
  logic [7:0] clr_vec;

  // Next-state logic
  always_comb begin
    cfg_en = wr_en && (wr_addr == OFS_CFG);
    cfg_d  = wr_data & LOG_MASK;

    set_vec             = '0;
    set_vec[BIT_FL_NC]  = fl_nc_evt  & cfg_q[BIT_FL_NC];
    set_vec[BIT_RAM_NC] = ram_nc_evt & cfg_q[BIT_RAM_NC];
    set_vec[BIT_FL_SB]  = fl_sb_evt  & cfg_q[BIT_FL_SB]  & sb_strap;
    set_vec[BIT_RAM_SB] = ram_sb_evt & cfg_q[BIT_RAM_SB] & sb_strap;

    clr_vec = (wr_en && (wr_addr == OFS_STATUS)) ? (wr_data & LOG_MASK) : 8'h00;

    status_en = (|set_vec) || (|clr_vec);
    status_d  = (status_q & ~clr_vec) | set_vec;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      status_q <= '0;
    end else begin
      if (cfg_en)    cfg_q    <= cfg_d;
      if (status_en) status_q <= status_d;
    end
  end

  assign fl_sb_acc   = set_vec[BIT_FL_SB];
  assign fl_nc_acc   = set_vec[BIT_FL_NC];
  assign ram_sb_acc  = set_vec[BIT_RAM_SB];
  assign ram_nc_acc  = set_vec[BIT_RAM_NC];
  assign fl_nc_pend  = status_q[BIT_FL_NC];
  assign ram_nc_pend = status_q[BIT_RAM_NC];
  assign irq         = |status_q;

  AST_FL_NC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    fl_nc_evt && cfg_q[BIT_FL_NC] |=> status_q[BIT_FL_NC]); // R2
  AST_RAM_NC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ram_nc_evt && cfg_q[BIT_RAM_NC] |=> status_q[BIT_RAM_NC]); // R2
  AST_FL_SB_NEEDS_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !sb_strap && !status_q[BIT_FL_SB] |=> !status_q[BIT_FL_SB]); // R3
  AST_RAM_SB_NEEDS_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !sb_strap && !status_q[BIT_RAM_SB] |=> !status_q[BIT_RAM_SB]); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[BIT_FL_NC] && !(wr_en && wr_addr == OFS_STATUS) |=> status_q[BIT_FL_NC]); // R4
  AST_IRQ_FOLLOWS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ram_nc_evt && cfg_q[BIT_RAM_NC] |=> irq); // R5

endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int MSTR_W  = 4,
  parameter int ATTR_W  = 8,
  parameter int SYN_W   = 8,
  parameter bit HAS_SYN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sb_acc,
  input  logic              nc_acc,
  input  logic              nc_pend,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MSTR_W-1:0] master_i,
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SYN_W-1:0]  syn_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [MSTR_W-1:0] master_q,
  output logic [ATTR_W-1:0] attr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [SYN_W-1:0]  syn_q
);

  logic load;

  // A pending non-correctable capture outranks any single-bit event
  always_comb begin
    load = nc_acc || (sb_acc && !nc_pend);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      master_q <= '0;
      attr_q   <= '0;
      data_q   <= '0;
    end else if (load) begin
      addr_q   <= addr_i;
      master_q <= master_i;
      attr_q   <= attr_i;
      data_q   <= data_i;
    end
  end

  generate
    if (HAS_SYN) begin : g_syn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    syn_q <= '0;
        else if (load) syn_q <= syn_i;
      end
    end else begin : g_no_syn
      logic unused_syn;
      assign unused_syn = ^syn_i;
      assign syn_q      = '0;
    end
  endgenerate

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sb_acc && !nc_acc |=> $stable(addr_q) && $stable(data_q)); // R8
  AST_NC_CAPTURE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    nc_pend && !nc_acc |=> $stable(addr_q) && $stable(master_q)); // R9
  AST_NC_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    nc_acc |=> addr_q == $past(addr_i) && attr_q == $past(attr_i)); // R6

endmodule

// File: rtl/ecc_log_unit.sv
module ecc_log_unit
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MSTR_W = 4,
  parameter int ATTR_W = 8,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sb_strap,
  input  logic              fl_sb_evt,
  input  logic              fl_nc_evt,
  input  logic [ADDR_W-1:0] fl_addr,
  input  logic [MSTR_W-1:0] fl_master,
  input  logic [ATTR_W-1:0] fl_attr,
  input  logic [DATA_W-1:0] fl_data,
  input  logic              ram_sb_evt,
  input  logic              ram_nc_evt,
  input  logic [ADDR_W-1:0] ram_addr,
  input  logic [MSTR_W-1:0] ram_master,
  input  logic [ATTR_W-1:0] ram_attr,
  input  logic [DATA_W-1:0] ram_data,
  input  logic [SYN_W-1:0]  ram_syndrome,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [RD_W-1:0]   reg_rdata,
  output logic              irq
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [7:0] cfg_q, status_q;
  logic fl_sb_acc, fl_nc_acc, ram_sb_acc, ram_nc_acc;
  logic fl_nc_pend, ram_nc_pend;
  logic wr_en;

  assign wr_en = reg_sel && reg_we;

  ecc_log_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sb_strap    (sb_strap),
    .wr_en       (wr_en),
    .wr_addr     (reg_addr),
    .wr_data     (reg_wdata),
    .fl_sb_evt   (fl_sb_evt),
    .fl_nc_evt   (fl_nc_evt),
    .ram_sb_evt  (ram_sb_evt),
    .ram_nc_evt  (ram_nc_evt),
    .cfg_q       (cfg_q),
    .status_q    (status_q),
    .fl_sb_acc   (fl_sb_acc),
    .fl_nc_acc   (fl_nc_acc),
    .ram_sb_acc  (ram_sb_acc),
    .ram_nc_acc  (ram_nc_acc),
    .fl_nc_pend  (fl_nc_pend),
    .ram_nc_pend (ram_nc_pend),
    .irq         (irq)
  );

  logic [ADDR_W-1:0] fl_cap_addr, ram_cap_addr;
  logic [MSTR_W-1:0] fl_cap_mstr, ram_cap_mstr;
  logic [ATTR_W-1:0] fl_cap_attr, ram_cap_attr;
  logic [DATA_W-1:0] fl_cap_data, ram_cap_data;
  logic [SYN_W-1:0]  fl_cap_syn,  ram_cap_syn;

  ecc_log_capture #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .MSTR_W (MSTR_W),
    .ATTR_W (ATTR_W), .SYN_W (SYN_W), .HAS_SYN (1'b0)
  ) u_fl_cap (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sb_acc   (fl_sb_acc),
    .nc_acc   (fl_nc_acc),
    .nc_pend  (fl_nc_pend),
    .addr_i   (fl_addr),
    .master_i (fl_master),
    .attr_i   (fl_attr),
    .data_i   (fl_data),
    .syn_i    ('0),
    .addr_q   (fl_cap_addr),
    .master_q (fl_cap_mstr),
    .attr_q   (fl_cap_attr),
    .data_q   (fl_cap_data),
    .syn_q    (fl_cap_syn)
  );

  ecc_log_capture #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .MSTR_W (MSTR_W),
    .ATTR_W (ATTR_W), .SYN_W (SYN_W), .HAS_SYN (1'b1)
  ) u_ram_cap (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sb_acc   (ram_sb_acc),
    .nc_acc   (ram_nc_acc),
    .nc_pend  (ram_nc_pend),
    .addr_i   (ram_addr),
    .master_i (ram_master),
    .attr_i   (ram_attr),
    .data_i   (ram_data),
    .syn_i    (ram_syndrome),
    .addr_q   (ram_cap_addr),
    .master_q (ram_cap_mstr),
    .attr_q   (ram_cap_attr),
    .data_q   (ram_cap_data),
    .syn_q    (ram_cap_syn)
  );

  logic unused_fl_syn;
  assign unused_fl_syn = ^fl_cap_syn;

  // Read mux, zero-extended
  always_comb begin
    reg_rdata = '0;
    if (reg_sel && !reg_we) begin
      case (reg_addr)
        OFS_CFG:      reg_rdata[7:0]        = cfg_q;
        OFS_STATUS:   reg_rdata[7:0]        = status_q;
        OFS_FL_ADDR:  reg_rdata[ADDR_W-1:0] = fl_cap_addr;
        OFS_FL_MSTR:  reg_rdata[MSTR_W-1:0] = fl_cap_mstr;
        OFS_FL_ATTR:  reg_rdata[ATTR_W-1:0] = fl_cap_attr;
        OFS_FL_DATA:  reg_rdata[DATA_W-1:0] = fl_cap_data;
        OFS_RAM_ADDR: reg_rdata[ADDR_W-1:0] = ram_cap_addr;
        OFS_RAM_MSTR: reg_rdata[MSTR_W-1:0] = ram_cap_mstr;
        OFS_RAM_ATTR: reg_rdata[ATTR_W-1:0] = ram_cap_attr;
        OFS_RAM_DATA: reg_rdata[DATA_W-1:0] = ram_cap_data;
        OFS_RAM_SYN:  reg_rdata[SYN_W-1:0]  = ram_cap_syn;
        default:      reg_rdata             = '0;
      endcase
    end
  end

  AST_CFG_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_sel && !reg_we && reg_addr == OFS_CFG |-> (reg_rdata & ~32'h33) == 32'h0); // R1
  AST_CAP_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en && reg_addr == OFS_RAM_ADDR && !ram_sb_acc && !ram_nc_acc |=> $stable(ram_cap_addr)); // R11
  AST_CROSS_ISOLATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ram_nc_acc && !fl_sb_acc && !fl_nc_acc |=> $stable(fl_cap_addr)); // R10

endmodule

// File: tb/ecc_log_unit_test.sv
module ecc_log_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {cfg[7:0], strap, fl_sb, fl_nc, ram_sb, ram_nc, expected status[7:0]}
  localparam logic [20:0] VECS [NVEC] = '{
    {8'h33, 1'b1, 4'b1111, 8'h33},
    {8'h33, 1'b0, 4'b1111, 8'h03},
    {8'h00, 1'b1, 4'b1111, 8'h00},
    {8'h11, 1'b1, 4'b1111, 8'h11},
    {8'h22, 1'b1, 4'b1111, 8'h22},
    {8'h33, 1'b1, 4'b0100, 8'h01},
    {8'h33, 1'b1, 4'b0010, 8'h20},
    {8'hFF, 1'b1, 4'b1001, 8'h12}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sb_strap;
  logic        fl_sb_evt, fl_nc_evt, ram_sb_evt, ram_nc_evt;
  logic [31:0] fl_addr, ram_addr, fl_data, ram_data;
  logic [3:0]  fl_master, ram_master;
  logic [7:0]  fl_attr, ram_attr, ram_syndrome;
  logic        reg_sel, reg_we;
  logic [7:0]  reg_addr, reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_log_unit uut (
    .clk(clk), .rst_n(rst_n), .sb_strap(sb_strap),
    .fl_sb_evt(fl_sb_evt), .fl_nc_evt(fl_nc_evt), .fl_addr(fl_addr),
    .fl_master(fl_master), .fl_attr(fl_attr), .fl_data(fl_data),
    .ram_sb_evt(ram_sb_evt), .ram_nc_evt(ram_nc_evt), .ram_addr(ram_addr),
    .ram_master(ram_master), .ram_attr(ram_attr), .ram_data(ram_data),
    .ram_syndrome(ram_syndrome),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] v);
    reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1;
    v = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic drive_ports(input logic [3:0] ev, input logic [31:0] fa, input logic [31:0] ra);
    {fl_sb_evt, fl_nc_evt, ram_sb_evt, ram_nc_evt} = ev;
    fl_addr = fa;  fl_master = fa[3:0];  fl_attr = fa[7:0] ^ 8'h5A;  fl_data = ~fa;
    ram_addr = ra; ram_master = ra[3:0]; ram_attr = ra[7:0] ^ 8'h5A; ram_data = ~ra;
    ram_syndrome = ra[7:0] ^ 8'hC3;
  endtask

  task automatic pulse(input logic [3:0] ev, input logic [31:0] fa, input logic [31:0] ra);
    @(negedge clk);
    drive_ports(ev, fa, ra);
    @(negedge clk);
    {fl_sb_evt, fl_nc_evt, ram_sb_evt, ram_nc_evt} = 4'b0000;
  endtask

  task automatic check_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    reg_read(a, v);
    check(req, v, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sb_strap = 1'b0;
    reg_sel = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    drive_ports(4'b0000, 32'h0, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state (R1, R5)
    check_reg("R1 cfg reset", 8'h43, 32'h0);
    check_reg("R2 status reset", 8'h47, 32'h0);
    check("R5 irq reset", {31'b0, irq}, 32'h0);
    check_reg("R6 flash addr reset", 8'h50, 32'h0);

    // Table walk over enables, strap and event patterns
    for (int i = 0; i < NVEC; i++) begin
      logic [20:0] v;
      v = VECS[i];
      reg_write(8'h43, v[20:13]);
      reg_write(8'h47, 8'hFF);
      sb_strap = v[12];
      check_reg("R1 cfg readback", 8'h43, {24'b0, v[20:13] & 8'h33});
      pulse(v[11:8], 32'hF000_0000 + i, 32'hA000_0000 + i);
      check_reg("R2/R3 status after event", 8'h47, {24'b0, v[7:0]});
      check("R5 irq level", {31'b0, irq}, {31'b0, v[7:0] != 8'h00});
    end

    // Capture contents and priority (R6, R7, R9)
    reg_write(8'h43, 8'h33);
    reg_write(8'h47, 8'hFF);
    sb_strap = 1'b1;
    pulse(4'b0010, 32'h0, 32'h1000_0004);
    check_reg("R6 ram addr", 8'h60, 32'h1000_0004);
    check_reg("R6 ram master", 8'h64, 32'h4);
    check_reg("R6 ram attr", 8'h68, 32'h5E);
    check_reg("R6 ram data", 8'h6C, ~32'h1000_0004);
    check_reg("R7 ram syndrome", 8'h70, 32'hC7);
    pulse(4'b0001, 32'h0, 32'h2000_0008);
    check_reg("R9 nc overwrites sb", 8'h60, 32'h2000_0008);
    pulse(4'b0010, 32'h0, 32'h3000_000C);
    check_reg("R9 sb keeps nc addr", 8'h60, 32'h2000_0008);
    check_reg("R9 sb keeps nc data", 8'h6C, ~32'h2000_0008);
    check_reg("R2 status ram flags", 8'h47, 32'h22);
    reg_write(8'h47, 8'h02);
    check("R5 irq held by remaining flag", {31'b0, irq}, 32'h1);
    reg_write(8'h47, 8'h20);
    check("R5 irq low when clear", {31'b0, irq}, 32'h0);
    pulse(4'b0010, 32'h0, 32'h3000_000C);
    check_reg("R9 sb captures after clear", 8'h60, 32'h3000_000C);

    // Disabled events leave captures and flags alone (R8, R2)
    reg_write(8'h47, 8'hFF);
    reg_write(8'h43, 8'h00);
    pulse(4'b0100, 32'h4444_0000, 32'h0);
    check_reg("R8 flash addr unchanged", 8'h50, 32'hF000_0007);
    check_reg("R2 disabled sets nothing", 8'h47, 32'h0);
    check("R5 irq stays low", {31'b0, irq}, 32'h0);

    // Capture registers are read-only (R11)
    reg_write(8'h50, 8'hAA);
    reg_write(8'h60, 8'h55);
    reg_write(8'h70, 8'h11);
    check_reg("R11 flash addr read-only", 8'h50, 32'hF000_0007);
    check_reg("R11 ram addr read-only", 8'h60, 32'h3000_000C);
    check_reg("R11 syndrome read-only", 8'h70, {24'b0, 8'h0C ^ 8'hC3});

    // Simultaneous events on both memories (R10)
    reg_write(8'h43, 8'h33);
    pulse(4'b0101, 32'hB100_0010, 32'hB200_0020);
    check_reg("R10 flash capture", 8'h50, 32'hB100_0010);
    check_reg("R10 ram capture", 8'h60, 32'hB200_0020);
    check_reg("R10 flash master", 8'h54, 32'h0);
    check_reg("R2 both nc flags", 8'h47, 32'h03);

    // Write-one-to-clear behaviour (R4)
    reg_write(8'h47, 8'h00);
    check_reg("R4 zero write no effect", 8'h47, 32'h03);
    reg_write(8'h47, 8'h01);
    check_reg("R4 clear one bit", 8'h47, 32'h02);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = 8'h47; reg_wdata = 8'h01;
    drive_ports(4'b0100, 32'hC000_0000, 32'h0);
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
    {fl_sb_evt, fl_nc_evt, ram_sb_evt, ram_nc_evt} = 4'b0000;
    check_reg("R4 set beats clear", 8'h47, 32'h03);

    // Strap low blocks single-bit capture too (R3)
    reg_write(8'h47, 8'hFF);
    sb_strap = 1'b0;
    pulse(4'b1000, 32'hD000_0000, 32'h0);
    check_reg("R3 strap low no flag", 8'h47, 32'h0);
    check_reg("R3 strap low no capture", 8'h50, 32'hC000_0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule